// File: doc/BRIEF.md
# Width-Converting Synchronous FIFO

This block is a single-clock FIFO whose write side and read side have different widths. One width is an integer multiple of the other. A wide-to-narrow instance breaks each accepted input word into several output words. A narrow-to-wide instance collects several input words and releases them as one output word. Both sides use a valid/ready handshake. The `count` output gives the number of complete output-width words held.

Data is stored as narrow slices in a circular array. The write pointer advances by the number of slices in one input word. The read pointer advances by the number of slices in one output word. Capacity is set by `DEPTH` in output-width words. The 16-bit-in/8-bit-out instance uses `DEPTH` = 8 and holds four input words. The 8-bit-in/16-bit-out instance uses `DEPTH` = 4 and holds eight input words.

A three-state fill machine governs the handshake outputs:
- FILL_EMPTY: nothing is stored.
- FILL_PART: some slices are stored, but the array is not full.
- FILL_FULL: every slice is occupied.

Its transitions are:
- FILL_EMPTY to FILL_PART on a push.
- FILL_PART to FILL_EMPTY when a pop drains the last slice.
- FILL_PART to FILL_FULL when a push fills the last free slot.
- FILL_FULL to FILL_PART on a pop.
- FILL_EMPTY to FILL_FULL directly only when one input word fills the whole array.

The next state always follows the next occupancy.

Top module: `width_conv_fifo`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `count` is 0, `out_valid` is low and `in_ready` is high.
- R2: Wide-to-narrow: slice k of an accepted input word (bits [k*OUT_W +: OUT_W]) is presented as the k-th output word. The least-significant slice comes first.
- R3: Narrow-to-wide: the k-th input word accepted for an output word appears at bits [k*IN_W +: IN_W] of that output word. The first word received sits in the least-significant position.
- R4: `count` equals the stored data measured in whole output words (rounded down when merging). It takes a handshake into account on the cycle after the handshake. It does not change in a cycle with no handshake.
- R5: A push and a pop may both complete in the same cycle. `count` then moves by the net change.
- R6: `in_ready` is low whenever the free narrow slots are fewer than one input word needs.
- R7: `out_valid` is high exactly when at least one complete output word is stored, that is, when `count` is non-zero.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R9: Capacity is `DEPTH` output words. With no reads, a 16→8 instance of `DEPTH` 8 accepts four words, then shows `count` 8 and `in_ready` low. An 8→16 instance of `DEPTH` 4 accepts eight words, then shows `count` 4 and `in_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Room for one whole input word |
| in_data | input | IN_W | Input word |
| out_valid | output | 1 | A complete output word is available |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | OUT_W | Output word |
| count | output | $clog2(DEPTH+1) | Occupancy in output words |

## Verification
The checker assumes that `in_valid` and `out_ready` hold known 0/1 values once reset is released. It also assumes that `DEPTH` times the output slice count is a multiple of the input slice count, so that no word straddles the wrap point. It makes no assumption about `in_data` being held while a word waits. The stimulus drives only 0/1 on both handshake inputs, changes `in_data` freely every cycle, and uses parameter sets that meet the alignment rule. A fill-without-reads phase, a drain phase, a continuous stream phase and a random phase reach the full, empty, simultaneous push/pop and stall conditions in both widths.

// File: rtl/wfc_pkg.sv
package wfc_pkg;

    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_PART,
        FILL_FULL
    } fill_state_e;

    function automatic int min_of(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/wfc_store.sv
module wfc_store #(
    parameter int SLICE_W = 8,
    parameter int SLOTS   = 8,
    parameter int WR_STEP = 2,
    parameter int RD_STEP = 1,
    localparam int PW     = $clog2(SLOTS)
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [PW-1:0]               wr_ptr,
    input  logic [WR_STEP*SLICE_W-1:0]  wr_data,
    input  logic [PW-1:0]               rd_ptr,
    output logic [RD_STEP*SLICE_W-1:0]  rd_data
);

    logic [SLICE_W-1:0] mem [SLOTS];

    // Slices of one input word occupy consecutive slots, low slice first.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < WR_STEP; k++) begin
                mem[wr_ptr + PW'(k)] <= wr_data[k*SLICE_W +: SLICE_W];
            end
        end
    end

    // Oldest slot maps to the least-significant slice of the output word.
    always_comb begin
        for (int k = 0; k < RD_STEP; k++) begin
            rd_data[k*SLICE_W +: SLICE_W] = mem[rd_ptr + PW'(k)];
        end
    end

endmodule

// File: rtl/wfc_ctrl.sv
module wfc_ctrl
    import wfc_pkg::*;
#(
    parameter int SLOTS   = 8,
    parameter int WR_STEP = 2,
    parameter int RD_STEP = 1,
    localparam int PW     = $clog2(SLOTS),
    localparam int OW     = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          out_valid,
    output logic          push,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [OW-1:0] occ
);

    fill_state_e state_q, state_d;
    logic [OW-1:0] occ_d;
    logic [OW-1:0] free_slots;
    logic          pop;

    assign free_slots = OW'(SLOTS) - occ;
    assign push       = in_valid & in_ready;
    assign pop        = out_valid & out_ready;

    always_comb begin
        occ_d = occ;
        if (push) occ_d = occ_d + OW'(WR_STEP);
        if (pop)  occ_d = occ_d - OW'(RD_STEP);
    end

    always_comb begin
        if (occ_d == '0)
            state_d = FILL_EMPTY;
        else if (occ_d == OW'(SLOTS))
            state_d = FILL_FULL;
        else
            state_d = FILL_PART;
    end

    // State register with occupancy and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
            occ     <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            state_q <= state_d;
            occ     <= occ_d;
            if (push) begin
                if (int'(wr_ptr) + WR_STEP >= SLOTS) wr_ptr <= '0;
                else                                 wr_ptr <= wr_ptr + PW'(WR_STEP);
            end
            if (pop) begin
                if (int'(rd_ptr) + RD_STEP >= SLOTS) rd_ptr <= '0;
                else                                 rd_ptr <= rd_ptr + PW'(RD_STEP);
            end
        end
    end

    // Handshake outputs per state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            FILL_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            FILL_PART: begin
                in_ready  = (free_slots >= OW'(WR_STEP));
                out_valid = (occ >= OW'(RD_STEP));
            end
            FILL_FULL: begin
                in_ready  = 1'b0;
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/width_conv_fifo.sv
module width_conv_fifo
    import wfc_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [IN_W-1:0]            in_data,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [OUT_W-1:0]           out_data,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int SLICE_W = min_of(IN_W, OUT_W);
    localparam int WR_STEP = IN_W / SLICE_W;
    localparam int RD_STEP = OUT_W / SLICE_W;
    localparam int SLOTS   = DEPTH * RD_STEP;
    localparam int PW      = $clog2(SLOTS);
    localparam int OW      = $clog2(SLOTS + 1);
    localparam int CW      = $clog2(DEPTH + 1);

    logic          push;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [OW-1:0] occ;

    wfc_ctrl #(
        .SLOTS   (SLOTS),
        .WR_STEP (WR_STEP),
        .RD_STEP (RD_STEP)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .push      (push),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .occ       (occ)
    );

    wfc_store #(
        .SLICE_W (SLICE_W),
        .SLOTS   (SLOTS),
        .WR_STEP (WR_STEP),
        .RD_STEP (RD_STEP)
    ) u_store (
        .clk     (clk),
        .wr_en   (push),
        .wr_ptr  (wr_ptr),
        .wr_data (in_data),
        .rd_ptr  (rd_ptr),
        .rd_data (out_data)
    );

    generate
        if (RD_STEP == 1) begin : g_split_count
            assign count = CW'(occ);
        end else begin : g_merge_count
            assign count = CW'(occ / OW'(RD_STEP));
        end
    endgenerate

endmodule

// File: rtl/wfc_checker.sv
module wfc_checker #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8,
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic [IN_W-1:0]            in_data,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [OUT_W-1:0]           out_data,
    input logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int SLICE_W = (IN_W < OUT_W) ? IN_W : OUT_W;
    localparam int WR_STEP = IN_W / SLICE_W;
    localparam int RD_STEP = OUT_W / SLICE_W;
    localparam int SLOTS   = DEPTH * RD_STEP;

    logic unused_data;
    assign unused_data = ^in_data;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (count == '0 && !out_valid && in_ready));

    assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(in_valid && in_ready) && !(out_valid && out_ready)) |=> $stable(count));

    generate
        if (RD_STEP == 1) begin : g_split_net
            assert_net_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_ready && out_valid && out_ready)
                |=> (int'(count) == int'($past(count)) + WR_STEP - 1));
        end
    endgenerate

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) * RD_STEP + WR_STEP > SLOTS) |-> !in_ready);

    assert_valid_tracks_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == (count != '0));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind width_conv_fifo wfc_checker #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W),
    .DEPTH (DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .count     (count)
);

// File: tb/sim_width_conv_fifo.sv
module sim_width_conv_fifo;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic rst_n;

    // u0: 16 -> 8, depth 8
    logic        a_in_valid, a_in_ready, a_out_valid, a_out_ready;
    logic [15:0] a_in_data;
    logic [7:0]  a_out_data;
    logic [3:0]  a_count;

    // u1: 8 -> 16, depth 4
    logic        b_in_valid, b_in_ready, b_out_valid, b_out_ready;
    logic [7:0]  b_in_data;
    logic [15:0] b_out_data;
    logic [2:0]  b_count;

    width_conv_fifo #(.IN_W(16), .OUT_W(8), .DEPTH(8)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(a_in_valid), .in_ready(a_in_ready), .in_data(a_in_data),
        .out_valid(a_out_valid), .out_ready(a_out_ready), .out_data(a_out_data),
        .count(a_count)
    );

    width_conv_fifo #(.IN_W(8), .OUT_W(16), .DEPTH(4)) u1 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(b_in_valid), .in_ready(b_in_ready), .in_data(b_in_data),
        .out_valid(b_out_valid), .out_ready(b_out_ready), .out_data(b_out_data),
        .count(b_count)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] qa[$];
    logic [7:0] qb[$];

    bit          a_both, b_both, a_stall, b_stall;
    logic [7:0]  a_prev;
    logic [15:0] b_prev;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit ea_v, eb_v;
        ea_v = (qa.size() >= 1);
        eb_v = (qb.size() >= 2);
        chk("R7", "u0 out_valid", 32'(a_out_valid), 32'(ea_v));
        chk("R6", "u0 in_ready", 32'(a_in_ready), 32'(8 - qa.size() >= 2));
        chk(a_both ? "R5" : "R4", "u0 count", 32'(a_count), 32'(qa.size()));
        if (ea_v) chk("R2", "u0 out_data", 32'(a_out_data), 32'(qa[0]));
        if (a_stall) chk("R8", "u0 held out_data", 32'(a_out_data), 32'(a_prev));
        chk("R7", "u1 out_valid", 32'(b_out_valid), 32'(eb_v));
        chk("R6", "u1 in_ready", 32'(b_in_ready), 32'(qb.size() < 8));
        chk(b_both ? "R5" : "R4", "u1 count", 32'(b_count), 32'(qb.size() / 2));
        if (eb_v) chk("R3", "u1 out_data", 32'(b_out_data), 32'({qb[1], qb[0]}));
        if (b_stall) chk("R8", "u1 held out_data", 32'(b_out_data), 32'(b_prev));
    endtask

    task automatic cycle(input bit av, input bit ar, input bit bv, input bit br);
        bit pa, ra, pb, rb;
        @(negedge clk);
        compare_all();
        a_in_valid  = av;
        a_in_data   = 16'($urandom);
        a_out_ready = ar;
        b_in_valid  = bv;
        b_in_data   = 8'($urandom);
        b_out_ready = br;
        pa = av && (8 - qa.size() >= 2);
        ra = ar && (qa.size() >= 1);
        pb = bv && (qb.size() < 8);
        rb = br && (qb.size() >= 2);
        a_stall = (qa.size() >= 1) && !ar;
        b_stall = (qb.size() >= 2) && !br;
        if (qa.size() >= 1) a_prev = qa[0];
        if (qb.size() >= 2) b_prev = {qb[1], qb[0]};
        a_both = pa && ra;
        b_both = pb && rb;
        if (ra) void'(qa.pop_front());
        if (rb) begin
            void'(qb.pop_front());
            void'(qb.pop_front());
        end
        if (pa) begin
            qa.push_back(a_in_data[7:0]);
            qa.push_back(a_in_data[15:8]);
        end
        if (pb) qb.push_back(b_in_data);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        rst_n = 1'b0;
        a_in_valid = 1'b0; a_out_ready = 1'b0; a_in_data = '0;
        b_in_valid = 1'b0; b_out_ready = 1'b0; b_in_data = '0;
        a_both = 1'b0; b_both = 1'b0; a_stall = 1'b0; b_stall = 1'b0;
        a_prev = '0; b_prev = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1", "u0 count", 32'(a_count), 32'd0);
        chk("R1", "u0 out_valid", 32'(a_out_valid), 32'd0);
        chk("R1", "u0 in_ready", 32'(a_in_ready), 32'd1);
        chk("R1", "u1 count", 32'(b_count), 32'd0);
        chk("R1", "u1 out_valid", 32'(b_out_valid), 32'd0);
        chk("R1", "u1 in_ready", 32'(b_in_ready), 32'd1);
        rst_n = 1'b1;

        // Fill without reads
        repeat (10) cycle(1'b1, 1'b0, 1'b1, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 1'b0);
        // R9: capacity reached
        chk("R9", "u0 full count", 32'(a_count), 32'd8);
        chk("R9", "u0 full in_ready", 32'(a_in_ready), 32'd0);
        chk("R9", "u1 full count", 32'(b_count), 32'd4);
        chk("R9", "u1 full in_ready", 32'(b_in_ready), 32'd0);

        // Drain
        repeat (12) cycle(1'b0, 1'b1, 1'b0, 1'b1);
        // Continuous streaming with simultaneous push and pop
        repeat (40) cycle(1'b1, 1'b1, 1'b1, 1'b1);
        // Random traffic with stalls
        for (int i = 0; i < 400; i++) begin
            cycle(1'($urandom), 1'(($urandom % 3) == 0), 1'($urandom), 1'(($urandom % 3) != 0));
        end
        cycle(1'b0, 1'b0, 1'b0, 1'b0);

        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule